// File: doc/BRIEF.md
# Sequenced Pre-Add Multiply-Accumulate Engine

This block is a small arithmetic engine that runs a fixed schedule of multiply-add steps, such as one pass of a PID control law, without any general-purpose register logic. Operands sit in three replicated operand memories (banks A, B and D). A counter-driven sequencer walks a program memory. Each program word selects one address in each bank, a post-add mode, and an optional write-back address. The datapath forms (D + B) × A and then either passes the product through, adds an external C operand, adds the running result, or clears the result.

Results are saturated to the operand width and written back into all three banks. A later instruction or a later pass can therefore use a result in any operand position. Pure additions and pure multiplications run on the same datapath by reading a stored constant 1 as the multiplier or a stored constant 0 as one pre-add term. Sums of more than two terms are chained, two terms per instruction, through the accumulate mode. Instructions issue one per cycle with no stalls. A start pulse runs one pass and a single-cycle done pulse marks the last result.

Top module: `pmac_engine`

## Requirements
- R1: While and after synchronous reset, with no start since, busy, done and wb_valid are 0 and acc_out is 0.
- R2: Post-add mode 0 (pass) makes the result equal to the signed product (D + B) × A, with operands taken as 18-bit two's complement and c_opnd ignored.
- R3: The pre-add sum D + B is truncated to 18 bits (wraps) before the multiply, so 131071 + 1 behaves as -131072.
- R4: Post-add mode 1 makes the result the product plus the signed 48-bit value on c_opnd, which is held stable for the whole pass.
- R5: Post-add mode 2 makes the result the product plus the result of the immediately preceding instruction, including when the instructions issue in back-to-back cycles.
- R6: Post-add mode 3 makes the result zero, whatever the operands are.
- R7: With bank A holding 1 at the selected address the result is D + B, and with bank B holding 0 it is D × A. Pure add and pure multiply therefore need no other datapath.
- R8: When an instruction has write enable set, wb_valid is 1 in the cycle its result appears on acc_out. In that cycle wb_addr is the instruction's write-back address and wb_data is the result saturated to the signed 18-bit range [-131072, 131071].
- R9: A write-back is stored at wb_addr in all three banks and can be read by later instructions. The load port writes ld_data at ld_addr into every bank whose ld_mask bit is set (bit 0 bank A, bit 1 bank B, bit 2 bank D).
- R10: The program word has these fields, from the LSB up: D address [8:0], B address [17:9], A address [26:18], mode [28:27], write-back address [37:29], write enable [38]. A start sampled at a clock edge issues instructions 0 to prog_last one per cycle. The result of instruction k appears 4 + k cycles after that edge. done is high for exactly one cycle, together with the last result.
- R11: A start that arrives while busy is 1 is ignored: it neither restarts nor extends the pass.
- R12: An instruction with write enable clear produces no wb_valid pulse and changes no bank.
- R13: While busy is 0, acc_out keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_we | input | 1 | Operand load strobe |
| ld_mask | input | 3 | Bank select for the load: bit 0 A, bit 1 B, bit 2 D |
| ld_addr | input | 9 | Operand load address |
| ld_data | input | 18 | Operand load value |
| pg_we | input | 1 | Program word write strobe |
| pg_addr | input | PROG_AW | Program word index |
| pg_word | input | 39 | Program word value |
| prog_last | input | PROG_AW | Index of the last instruction of a pass |
| start | input | 1 | Pass start pulse |
| c_opnd | input | 48 | External C addend for mode 1 |
| busy | output | 1 | Pass running or results still in the pipeline |
| done | output | 1 | One-cycle pulse with the final result |
| wb_valid | output | 1 | Write-back happening this cycle |
| wb_addr | output | 9 | Write-back address |
| wb_data | output | 18 | Saturated write-back value |
| acc_out | output | 48 | Current 48-bit result register |

## Verification
The bench keeps the 18-bit operands, the 9-bit bank address and the 48-bit result, and shrinks the program store to 16 words (PROG_AW = 4). At full operand width the most negative operand, the pre-add wrap and both saturation limits can be driven with exact known products, such as 2^34 and -17179738112. The short program store still holds the three-instruction chains that exercise accumulation, back-to-back issue and reuse of written-back results in every operand position.

// File: rtl/pmac_pkg.sv
// Shared definitions for the sequenced pre-add multiply-accumulate engine.
// Assumes: the post-add mode field of a program word is two bits wide.
package pmac_pkg;

    typedef enum logic [1:0] {
        PM_PASS  = 2'd0,
        PM_ADDC  = 2'd1,
        PM_ACCUM = 2'd2,
        PM_CLEAR = 2'd3
    } post_mode_e;

endpackage

// File: rtl/pmac_opmem.sv
// One operand bank: single write port, single registered read port.
// Assumes: read-before-write when both ports hit one address in one cycle;
// contents are not reset and must be loaded before use.
module pmac_opmem #(
    parameter int DW = 18,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Write the bank and register the read word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
        rd_data <= store[rd_addr];
    end

endmodule

// File: rtl/pmac_seq.sv
// Program store and counter sequencer. Issues one program word per cycle
// from index 0 to the latched last index after an accepted start.
// Assumes: prog_last is sampled only when a start is accepted; the program
// store is written only while idle.
module pmac_seq #(
    parameter int PAW  = 6,
    parameter int PW_W = 39
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pg_we,
    input  logic [PAW-1:0]  pg_addr,
    input  logic [PW_W-1:0] pg_word,
    input  logic [PAW-1:0]  prog_last,
    input  logic            start,
    input  logic            hold,
    output logic            running,
    output logic            iss_valid,
    output logic            iss_last,
    output logic [PW_W-1:0] iss_word
);

    localparam int PDEPTH = 1 << PAW;

    logic [PW_W-1:0] prog [PDEPTH];
    logic [PAW-1:0]  pc;
    logic [PAW-1:0]  last_q;

    // Program store write port.
    always_ff @(posedge clk) begin
        if (pg_we) begin
            prog[pg_addr] <= pg_word;
        end
    end

    // Run control: accept start only when fully idle, then count to last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            pc      <= '0;
            last_q  <= '0;
        end else if (start && !running && !hold) begin
            running <= 1'b1;
            pc      <= '0;
            last_q  <= prog_last;
        end else if (running) begin
            pc <= pc + 1'b1;
            if (pc == last_q) begin
                running <= 1'b0;
            end
        end
    end

    // Issue the addressed word while running.
    always_comb begin
        iss_valid = running;
        iss_last  = running && (pc == last_q);
        iss_word  = prog[pc];
    end

endmodule

// File: rtl/pmac_dpath.sv
// Pipelined pre-add, multiply and post-add datapath with write-back
// saturation. Stage 1 is the bank read (operands arrive registered from the
// banks), stage 2 the pre-add, stage 3 the multiply, stage 4 the result.
// Assumes: c_opnd is stable while an add-C instruction is in stage 3.
module pmac_dpath
    import pmac_pkg::*;
#(
    parameter int DW    = 18,
    parameter int AW    = 9,
    parameter int ACC_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic             iss_last,
    input  logic [1:0]       iss_mode,
    input  logic             iss_wben,
    input  logic [AW-1:0]    iss_wbaddr,
    input  logic [DW-1:0]    opa,
    input  logic [DW-1:0]    opb,
    input  logic [DW-1:0]    opd,
    input  logic [ACC_W-1:0] c_opnd,
    output logic             inflight,
    output logic             res_valid,
    output logic             res_last,
    output logic             wb_valid,
    output logic [AW-1:0]    wb_addr,
    output logic [DW-1:0]    wb_data,
    output logic [ACC_W-1:0] acc
);

    localparam int NSTG = 4;
    localparam int PW   = 2 * DW;
    localparam logic signed [ACC_W-1:0] SAT_HI = {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

    logic [NSTG:1]        vld;
    logic [NSTG:1]        lst;
    logic [NSTG:1]        wbe;
    logic [AW-1:0]        wba [1:NSTG];
    logic [1:0]           md  [1:3];

    logic signed [DW-1:0]    pre;
    logic signed [DW-1:0]    a2;
    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_x;
    logic signed [ACC_W-1:0] acc_q;

    // Control tags travel alongside the data, one slot per stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
            lst <= '0;
            wbe <= '0;
            for (int s = 1; s <= NSTG; s++) begin
                wba[s] <= '0;
            end
            for (int s = 1; s <= 3; s++) begin
                md[s] <= '0;
            end
        end else begin
            vld[1] <= iss_valid;
            lst[1] <= iss_last;
            wbe[1] <= iss_wben;
            wba[1] <= iss_wbaddr;
            md[1]  <= iss_mode;
            for (int s = 2; s <= NSTG; s++) begin
                vld[s] <= vld[s-1];
                lst[s] <= lst[s-1];
                wbe[s] <= wbe[s-1];
                wba[s] <= wba[s-1];
            end
            for (int s = 2; s <= 3; s++) begin
                md[s] <= md[s-1];
            end
        end
    end

    // Stage 2: wrapping pre-add of D and B, carry A along.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
            a2  <= '0;
        end else begin
            pre <= $signed(opd) + $signed(opb);
            a2  <= $signed(opa);
        end
    end

    // Stage 3: signed full-width multiply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod <= '0;
        end else begin
            prod <= pre * a2;
        end
    end

    assign prod_x = {{(ACC_W-PW){prod[PW-1]}}, prod};

    // Stage 4: post-add per mode; result register moves only on valid work.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (vld[3]) begin
            unique case (post_mode_e'(md[3]))
                PM_PASS:  acc_q <= prod_x;
                PM_ADDC:  acc_q <= prod_x + $signed(c_opnd);
                PM_ACCUM: acc_q <= prod_x + acc_q;
                PM_CLEAR: acc_q <= '0;
            endcase
        end
    end

    // Saturate the result to the operand range for write-back.
    always_comb begin
        if (acc_q > SAT_HI) begin
            wb_data = SAT_HI[DW-1:0];
        end else if (acc_q < SAT_LO) begin
            wb_data = SAT_LO[DW-1:0];
        end else begin
            wb_data = acc_q[DW-1:0];
        end
    end

    // Stage 4 outputs.
    always_comb begin
        inflight  = |vld;
        res_valid = vld[NSTG];
        res_last  = vld[NSTG] & lst[NSTG];
        wb_valid  = vld[NSTG] & wbe[NSTG];
        wb_addr   = wba[NSTG];
        acc       = acc_q;
    end

endmodule

// File: rtl/pmac_engine.sv
// Top of the sequenced pre-add multiply-accumulate engine. Three replicated
// operand banks (A, B, D) feed the datapath; results are written back into
// all three. The load port writes the banks selected by ld_mask.
// Assumes: loads and program writes happen only while busy is low, and a
// program does not read an address written back less than five cycles
// before that read is issued.
module pmac_engine #(
    parameter int DW      = 18,
    parameter int AW      = 9,
    parameter int ACC_W   = 48,
    parameter int PROG_AW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_we,
    input  logic [2:0]           ld_mask,
    input  logic [AW-1:0]        ld_addr,
    input  logic [DW-1:0]        ld_data,
    input  logic                 pg_we,
    input  logic [PROG_AW-1:0]   pg_addr,
    input  logic [4*AW+2:0]      pg_word,
    input  logic [PROG_AW-1:0]   prog_last,
    input  logic                 start,
    input  logic [ACC_W-1:0]     c_opnd,
    output logic                 busy,
    output logic                 done,
    output logic                 wb_valid,
    output logic [AW-1:0]        wb_addr,
    output logic [DW-1:0]        wb_data,
    output logic [ACC_W-1:0]     acc_out
);

    localparam int NBANK  = 3;
    localparam int PW_W   = 4 * AW + 3;
    localparam int F_MODE = 3 * AW;
    localparam int F_WBA  = 3 * AW + 2;
    localparam int F_WBE  = 4 * AW + 2;

    logic            running;
    logic            iss_valid;
    logic            iss_last;
    logic [PW_W-1:0] iss_word;
    logic            inflight;
    logic            res_valid;
    logic            res_last;
    logic [AW-1:0]   rd_addr [NBANK];
    logic [DW-1:0]   bank_q  [NBANK];

    pmac_seq #(
        .PAW  (PROG_AW),
        .PW_W (PW_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pg_we     (pg_we),
        .pg_addr   (pg_addr),
        .pg_word   (pg_word),
        .prog_last (prog_last),
        .start     (start),
        .hold      (inflight),
        .running   (running),
        .iss_valid (iss_valid),
        .iss_last  (iss_last),
        .iss_word  (iss_word)
    );

    // Bank read addresses: bank 0 = A, 1 = B, 2 = D.
    always_comb begin
        rd_addr[0] = iss_word[3*AW-1:2*AW];
        rd_addr[1] = iss_word[2*AW-1:AW];
        rd_addr[2] = iss_word[AW-1:0];
    end

    // One bank per operand position; write-back takes priority over load.
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic          bk_we;
        logic [AW-1:0] bk_wa;
        logic [DW-1:0] bk_wd;

        // Select the bank write source.
        always_comb begin
            bk_we = wb_valid | (ld_we & ld_mask[g]);
            bk_wa = wb_valid ? wb_addr : ld_addr;
            bk_wd = wb_valid ? wb_data : ld_data;
        end

        pmac_opmem #(
            .DW (DW),
            .AW (AW)
        ) u_mem (
            .clk     (clk),
            .wr_en   (bk_we),
            .wr_addr (bk_wa),
            .wr_data (bk_wd),
            .rd_addr (rd_addr[g]),
            .rd_data (bank_q[g])
        );
    end

    pmac_dpath #(
        .DW    (DW),
        .AW    (AW),
        .ACC_W (ACC_W)
    ) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .iss_valid  (iss_valid),
        .iss_last   (iss_last),
        .iss_mode   (iss_word[F_MODE+1:F_MODE]),
        .iss_wben   (iss_word[F_WBE]),
        .iss_wbaddr (iss_word[F_WBA+AW-1:F_WBA]),
        .opa        (bank_q[0]),
        .opb        (bank_q[1]),
        .opd        (bank_q[2]),
        .c_opnd     (c_opnd),
        .inflight   (inflight),
        .res_valid  (res_valid),
        .res_last   (res_last),
        .wb_valid   (wb_valid),
        .wb_addr    (wb_addr),
        .wb_data    (wb_data),
        .acc        (acc_out)
    );

    // Pass status.
    always_comb begin
        busy = running | inflight;
        done = res_valid & res_last;
    end

endmodule

// File: rtl/pmac_checker.sv
// Port-level properties of the engine, bound to every instance.
// Assumes: the top-level port names of pmac_engine.
module pmac_checker #(
    parameter int DW    = 18,
    parameter int ACC_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             wb_valid,
    input logic [DW-1:0]    wb_data,
    input logic [ACC_W-1:0] acc_out
);

    localparam logic signed [ACC_W-1:0] HI = {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] LO = ~HI;

    AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
    AST_DONE_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R11
    AST_START_TAKEN:  assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R10
    AST_WB_IN_PASS:   assert property (@(posedge clk) disable iff (!rst_n) wb_valid |-> busy); // R8
    AST_SAT_TOP:      assert property (@(posedge clk) disable iff (!rst_n)
                          (wb_valid && ($signed(acc_out) > HI)) |-> (wb_data == HI[DW-1:0])); // R8
    AST_SAT_BOTTOM:   assert property (@(posedge clk) disable iff (!rst_n)
                          (wb_valid && ($signed(acc_out) < LO)) |-> (wb_data == LO[DW-1:0])); // R8
    AST_IDLE_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !busy |=> $stable(acc_out)); // R13

endmodule

bind pmac_engine pmac_checker #(
    .DW    (DW),
    .ACC_W (ACC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .wb_valid (wb_valid),
    .wb_data  (wb_data),
    .acc_out  (acc_out)
);

// File: tb/pmac_engine_bench.sv
module pmac_engine_bench;

    localparam int DW = 18;
    localparam int AW = 9;
    localparam int CW = 48;
    localparam int PA = 4;

    typedef struct packed {
        logic signed [17:0] a;
        logic signed [17:0] b;
        logic signed [17:0] d;
        logic signed [47:0] c;
        logic [1:0]         mode;
        logic signed [47:0] exp;
        logic [7:0]         req;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{ 18'sd3,       18'sd4,      18'sd5,      48'sd77,   2'd0, 48'sd27,            8'd2 }, // R2 c ignored
        '{-18'sd2,       18'sd7,     -18'sd10,     48'sd0,    2'd0, 48'sd6,             8'd2 }, // R2
        '{ 18'sd1,       18'sd100,    18'sd23,     48'sd0,    2'd0, 48'sd123,           8'd7 }, // R7 add only
        '{ 18'sd1000,    18'sd0,     -18'sd7,      48'sd0,    2'd0, -48'sd7000,         8'd7 }, // R7 multiply only
        '{ 18'sd1,       18'sd131071, 18'sd1,      48'sd0,    2'd0, -48'sd131072,       8'd3 }, // R3 wrap
        '{ 18'sd2,       18'sd3,      18'sd4,      48'sd1000, 2'd1, 48'sd1014,          8'd4 }, // R4
        '{-18'sd3,       18'sd2,      18'sd2,     -48'sd50,   2'd1, -48'sd62,           8'd4 }, // R4
        '{ 18'sd5,       18'sd5,      18'sd5,      48'sd9,    2'd3, 48'sd0,             8'd6 }, // R6
        '{-18'sd131072, -18'sd65536, -18'sd65536,  48'sd0,    2'd0, 48'sd17179869184,   8'd8 }, // R8 high
        '{-18'sd131072,  18'sd0,      18'sd131071, 48'sd0,    2'd0, -48'sd17179738112,  8'd8 }  // R8 low
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ld_we = 1'b0;
    logic [2:0]     ld_mask = '0;
    logic [AW-1:0]  ld_addr = '0;
    logic [DW-1:0]  ld_data = '0;
    logic           pg_we = 1'b0;
    logic [PA-1:0]  pg_addr = '0;
    logic [38:0]    pg_word = '0;
    logic [PA-1:0]  prog_last = '0;
    logic           start = 1'b0;
    logic [CW-1:0]  c_opnd = '0;
    logic           busy;
    logic           done;
    logic           wb_valid;
    logic [AW-1:0]  wb_addr;
    logic [DW-1:0]  wb_data;
    logic [CW-1:0]  acc_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int t0 = 0;
    int wb_n = 0;
    int done_n = 0;
    int done_cyc = 0;
    logic [AW-1:0] log_addr [16];
    logic [DW-1:0] log_data [16];
    int            log_cyc  [16];

    pmac_engine #(
        .DW (DW), .AW (AW), .ACC_W (CW), .PROG_AW (PA)
    ) u_pmac_engine (
        .clk (clk), .rst_n (rst_n), .ld_we (ld_we), .ld_mask (ld_mask),
        .ld_addr (ld_addr), .ld_data (ld_data), .pg_we (pg_we),
        .pg_addr (pg_addr), .pg_word (pg_word), .prog_last (prog_last),
        .start (start), .c_opnd (c_opnd), .busy (busy), .done (done),
        .wb_valid (wb_valid), .wb_addr (wb_addr), .wb_data (wb_data),
        .acc_out (acc_out)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Log write-backs and done pulses half a cycle after the edge.
    always @(negedge clk) begin
        if (rst_n && wb_valid && wb_n < 16) begin
            log_addr[wb_n] = wb_addr;
            log_data[wb_n] = wb_data;
            log_cyc[wb_n]  = cyc;
            wb_n = wb_n + 1;
        end
        if (rst_n && done) begin
            done_n   = done_n + 1;
            done_cyc = cyc;
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] sat18(input logic signed [47:0] v);
        if (v > 48'sd131071)       return 18'h1FFFF;
        else if (v < -48'sd131072) return 18'h20000;
        else                       return v[17:0];
    endfunction

    function automatic logic [38:0] mkw(input bit we, input int wa, input logic [1:0] m,
                                        input int a, input int b, input int d);
        return {we, 9'(wa), m, 9'(a), 9'(b), 9'(d)};
    endfunction

    task automatic ld(input logic [2:0] m, input int a, input logic [DW-1:0] v);
        @(posedge clk); #1;
        ld_we = 1'b1; ld_mask = m; ld_addr = 9'(a); ld_data = v;
        @(posedge clk); #1;
        ld_we = 1'b0;
    endtask

    task automatic pg(input int i, input logic [38:0] w);
        @(posedge clk); #1;
        pg_we = 1'b1; pg_addr = PA'(i); pg_word = w;
        @(posedge clk); #1;
        pg_we = 1'b0;
    endtask

    task automatic launch();
        @(posedge clk); #1;
        wb_n = 0; done_n = 0; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0; t0 = cyc;
        for (int k = 0; k < 40 && done_n == 0; k++) @(posedge clk);
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic load_accum_prog();
        pg(0, mkw(1'b0, 0,  2'd0, 1, 40, 40));
        pg(1, mkw(1'b0, 0,  2'd2, 1, 41, 41));
        pg(2, mkw(1'b1, 50, 2'd2, 1, 42, 42));
        prog_last = PA'(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        logic [CW-1:0] held;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && wb_valid == 1'b0, "R1 flags in reset", {busy, done, wb_valid}, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && wb_valid == 1'b0, "R1 flags after reset", {busy, done, wb_valid}, 0);
        chk(acc_out == '0, "R1 acc_out", acc_out, 0);

        // Constants 0 and 1 in every bank.
        ld(3'b111, 0, 18'd0);
        ld(3'b111, 1, 18'd1);

        // Single-instruction table.
        for (int i = 0; i < NV; i++) begin
            ld(3'b001, 10, VECS[i].a);
            ld(3'b010, 11, VECS[i].b);
            ld(3'b100, 12, VECS[i].d);
            c_opnd = VECS[i].c;
            pg(0, mkw(1'b1, 20, VECS[i].mode, 10, 11, 12));
            prog_last = '0;
            launch();
            chk($signed(acc_out) == VECS[i].exp, $sformatf("R%0d vec %0d result", VECS[i].req, i),
                $signed(acc_out), VECS[i].exp);
            chk(wb_n == 1, $sformatf("R8 vec %0d writeback count", i), wb_n, 1);
            chk(log_data[0] == sat18(VECS[i].exp), $sformatf("R8 vec %0d saturated data", i),
                log_data[0], sat18(VECS[i].exp));
            chk(log_addr[0] == 9'd20, $sformatf("R8 vec %0d address", i), log_addr[0], 20);
        end

        // Chained accumulation: 11 + 22 + 33, only the last written back.
        ld(3'b010, 40, 18'd10); ld(3'b010, 41, 18'd20); ld(3'b010, 42, 18'd30);
        ld(3'b100, 40, 18'd1);  ld(3'b100, 41, 18'd2);  ld(3'b100, 42, 18'd3);
        c_opnd = 48'd999;
        load_accum_prog();
        launch();
        chk($signed(acc_out) == 66, "R5 accumulated sum", $signed(acc_out), 66);
        chk(wb_n == 1, "R12 only enabled write-back", wb_n, 1);
        chk(log_data[0] == 18'd66 && log_addr[0] == 9'd50, "R8 chain write-back", log_data[0], 66);
        chk(log_cyc[0] == t0 + 6, "R10 last result latency", log_cyc[0] - t0, 6);
        chk(done_n == 1 && done_cyc == t0 + 6, "R10 done pulse timing", done_cyc - t0, 6);

        // Idle hold.
        held = acc_out;
        repeat (10) @(posedge clk);
        #1;
        chk(acc_out == held && wb_n == 1, "R13 result held while idle", acc_out, held);

        // Reuse of a written-back value in each operand position.
        pg(0, mkw(1'b1, 51, 2'd0, 1, 0, 50));
        pg(1, mkw(1'b1, 52, 2'd0, 50, 0, 1));
        pg(2, mkw(1'b1, 53, 2'd0, 1, 50, 0));
        prog_last = PA'(2);
        launch();
        chk(wb_n == 3, "R9 write-back count", wb_n, 3);
        for (int k = 0; k < 3; k++) begin
            chk(log_data[k] == 18'd66, $sformatf("R9 reuse slot %0d", k), log_data[k], 66);
            chk(log_cyc[k] == t0 + 4 + k, $sformatf("R10 back-to-back slot %0d", k), log_cyc[k] - t0, 4 + k);
        end

        // Second start while busy.
        load_accum_prog();
        @(posedge clk); #1;
        wb_n = 0; done_n = 0; start = 1'b1;
        @(posedge clk); #1; start = 1'b0; t0 = cyc;
        @(posedge clk); #1; start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
        repeat (20) @(posedge clk);
        #1;
        chk(done_n == 1, "R11 single done", done_n, 1);
        chk(wb_n == 1 && done_cyc == t0 + 6, "R11 pass not restarted", done_cyc - t0, 6);
        chk($signed(acc_out) == 66, "R11 result", $signed(acc_out), 66);

        summary();
        $finish;
    end

endmodule